// File: doc/BRIEF.md
# Asynchronous Memory Access Timing Controller

This block turns single requests from an internal port into the chip-select, output-enable and write-enable strobes for one region of asynchronous external memory, such as SRAM, NOR flash or a NAND device whose ready line is wired to the wait pin. A request carries an address, a read/write flag and write data, and is taken with a valid/ready handshake. Each access goes through four phases: setup, strobe, hold and turnaround. Every phase length comes from a configuration word. Reads and writes have separate setup, strobe and hold widths. The turnaround width is shared, and each field holds the cycle count minus one.

The configuration word also holds three mode bits. The select-strobe bit makes chip select follow the strobe instead of covering the whole access. The extended-wait bit lets the external wait pin stretch the strobe phase, and a timeout counter ends a stretch that lasts too long. The width bit chooses between an 8-bit and a full-width external data bus. A copy of the configuration word is taken each time a request is accepted, so a write to the configuration during an access only changes the next access.

The controller is a five-state machine. IDLE moves to SETUP when a request is taken (transition *accept*). SETUP moves to STROBE when the setup count runs out (*setup_done*). STROBE moves to HOLD when the strobe count is at its last cycle and either no wait is pending or the wait timeout has expired (*strobe_done*). HOLD moves to TURN when the hold count runs out (*hold_done*). In the last TURN cycle the controller either accepts a new request and goes straight to SETUP (*chain*) or returns to IDLE (*rest*).

Top module: `amt_ctrl`

## Requirements
- R1: A timing field value v gives a phase of v+1 cycles. Setup, strobe and hold use the read fields for a read and the write fields for a write. The configuration word is laid out as follows: bits [2:0] write hold, [8:3] write strobe, [12:9] write setup, [15:13] read hold, [21:16] read strobe, [25:22] read setup, [27:26] turnaround, bit 28 bus width, bit 29 wait enable, bit 30 select-strobe.
- R2: After hold, the bus stays idle (chip select, output enable and write enable all high) for turnaround+1 cycles. `req_ready` is low from the cycle after a request is accepted until the last of those cycles. It is high in that last cycle, and a request offered then starts its setup in the very next cycle.
- R3: With select-strobe 0, `mem_cs_n` is low for every setup, strobe and hold cycle. With select-strobe 1, it is low only in strobe cycles.
- R4: `mem_oe_n` is low only in the strobe cycles of a read, and `mem_we_n` is low only in the strobe cycles of a write. The two are never low together.
- R5: With wait enable 0, `mem_wait` has no effect on any phase length.
- R6: With wait enable 1, the strobe phase stays in its last cycle while `mem_wait` is high. It ends at the close of the first last-phase cycle in which `mem_wait` is low.
- R7: With wait enable 1, if `mem_wait` stays high, the strobe phase is forced to end after strobe+WAIT_LIMIT cycles (256 by default). `err_timeout` then pulses for one cycle in the first hold cycle. It stays low for any access that did not time out.
- R8: `mem_addr` carries the request address from the first setup cycle to the last hold cycle and is zero otherwise. `mem_dout_en` is high over exactly those cycles for a write and never high for a read. While it is high, `mem_dout` carries the write data.
- R9: Read data is sampled at the end of the last strobe cycle. `rd_valid` pulses once, in the first hold cycle, with the sample on `rd_data`. A write produces no `rd_valid` pulse.
- R10: With bus width 0, bits above bit 7 of `mem_dout` and `rd_data` are zero. With bus width 1, all 16 bits pass through.
- R11: A configuration write while an access is in progress does not change any phase of that access, including its turnaround. It applies from the next accepted request.
- R12: After reset, the strobes are high, `mem_dout_en`, `rd_valid` and `err_timeout` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 31 | New configuration word (layout in R1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| rd_data | output | DW | Sampled read data |
| err_timeout | output | 1 | One-cycle pulse when a wait stretch was cut off |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | External address |
| mem_dout | output | DW | External write data |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DW | External read data |
| mem_wait | input | 1 | External wait / ready-busy line, high = wait |

## Verification
A wrong phase state or a miscounted phase counter shows up in the very same access. It changes the number of cycles that chip select, output enable or write enable is low, or where the turnaround gap falls, so the bench measures each of these lengths on every access over a sweep of field values, modes and bus widths. A broken wait or timeout path shows within one strobe phase, as a strobe of the wrong length or a missing or stray `err_timeout` pulse. A stale or early configuration copy shows in the access that straddles a configuration write. Read sampling is checked by feeding data that changes on every strobe cycle, so a sample taken one cycle early or late gives a wrong value in the first hold cycle.

// File: rtl/amt_pkg.sv
package amt_pkg;

    // Field widths of the configuration word
    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 3;
    localparam int TURN_W   = 2;

    // Phase counter is as wide as the widest field
    localparam int CNT_W =
        (STROBE_W >= SETUP_W && STROBE_W >= HOLD_W && STROBE_W >= TURN_W) ? STROBE_W :
        (SETUP_W  >= HOLD_W  && SETUP_W  >= TURN_W)                       ? SETUP_W  :
        (HOLD_W   >= TURN_W)                                              ? HOLD_W   : TURN_W;

    typedef struct packed {
        logic                sel_strobe;
        logic                ext_wait;
        logic                wide;
        logic [TURN_W-1:0]   turn;
        logic [SETUP_W-1:0]  rd_setup;
        logic [STROBE_W-1:0] rd_strobe;
        logic [HOLD_W-1:0]   rd_hold;
        logic [SETUP_W-1:0]  wr_setup;
        logic [STROBE_W-1:0] wr_strobe;
        logic [HOLD_W-1:0]   wr_hold;
    } amt_cfg_t;

    localparam int CFG_W = $bits(amt_cfg_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TURN
    } amt_phase_t;

endpackage

// File: rtl/amt_cfg_store.sv
module amt_cfg_store
    import amt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             capture,
    input  logic             capture_wr,
    output amt_cfg_t         cfg_act,
    output logic [CNT_W-1:0] first_setup
);

    amt_cfg_t cfg_live;

    // Software-visible word, updated on every write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_live <= '0;
        end else if (cfg_we) begin
            cfg_live <= amt_cfg_t'(cfg_wdata);
        end
    end

    // Copy used by the running access, taken only at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_act <= '0;
        end else if (capture) begin
            cfg_act <= cfg_live;
        end
    end

    // Setup length of the access being accepted, from the live word
    always_comb begin
        first_setup = capture_wr ? CNT_W'(cfg_live.wr_setup) : CNT_W'(cfg_live.rd_setup);
    end

endmodule

// File: rtl/amt_phase_cnt.sv
module amt_phase_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         at_last
);

    logic [W-1:0] cnt_q;

    // Counts down and parks at zero until reloaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        at_last = (cnt_q == '0);
    end

endmodule

// File: rtl/amt_wait_timer.sv
module amt_wait_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stalled,
    output logic expire
);

    localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] run_q;

    // Counts consecutive stalled cycles; clears as soon as the stall ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!stalled) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        expire = stalled && (run_q == LAST);
    end

endmodule

// File: rtl/amt_ctrl.sv
module amt_ctrl
    import amt_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int NARROW_W   = 8,
    parameter int WAIT_LIMIT = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             err_timeout,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dout_en,
    input  logic [DW-1:0]    mem_din,
    input  logic             mem_wait
);

    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    amt_phase_t       phase_q, phase_d;
    amt_cfg_t         cfg_act;
    logic [CNT_W-1:0] first_setup;
    logic [CNT_W-1:0] ld_val;
    logic             ld;
    logic             at_last;
    logic             accept;
    logic             leave_strobe;
    logic             wait_pending;
    logic             stalled;
    logic             expire;
    logic             op_wr_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             rd_valid_q;
    logic             err_q;
    logic [DW-1:0]    rd_data_q;
    logic [DW-1:0]    lane_mask;

    amt_cfg_store u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .capture    (accept),
        .capture_wr (req_write),
        .cfg_act    (cfg_act),
        .first_setup(first_setup)
    );

    amt_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .load_val(ld_val),
        .at_last (at_last)
    );

    amt_wait_timer #(.LIMIT(WAIT_LIMIT)) u_wtmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .stalled(stalled),
        .expire (expire)
    );

    always_comb begin
        wait_pending = cfg_act.ext_wait && mem_wait;
        stalled      = (phase_q == PH_STROBE) && at_last && wait_pending;
        lane_mask    = cfg_act.wide ? '1 : NARROW_MASK;
    end

    // Next-state logic
    always_comb begin
        phase_d      = phase_q;
        ld           = 1'b0;
        ld_val       = '0;
        accept       = 1'b0;
        leave_strobe = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin                      // accept
                    accept  = 1'b1;
                    phase_d = PH_SETUP;
                    ld      = 1'b1;
                    ld_val  = first_setup;
                end
            end
            PH_SETUP: begin
                if (at_last) begin                        // setup_done
                    phase_d = PH_STROBE;
                    ld      = 1'b1;
                    ld_val  = op_wr_q ? CNT_W'(cfg_act.wr_strobe) : CNT_W'(cfg_act.rd_strobe);
                end
            end
            PH_STROBE: begin
                if (at_last && (!wait_pending || expire)) begin   // strobe_done
                    leave_strobe = 1'b1;
                    phase_d      = PH_HOLD;
                    ld           = 1'b1;
                    ld_val       = op_wr_q ? CNT_W'(cfg_act.wr_hold) : CNT_W'(cfg_act.rd_hold);
                end
            end
            PH_HOLD: begin
                if (at_last) begin                        // hold_done
                    phase_d = PH_TURN;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(cfg_act.turn);
                end
            end
            PH_TURN: begin
                if (at_last) begin
                    if (req_valid) begin                  // chain
                        accept  = 1'b1;
                        phase_d = PH_SETUP;
                        ld      = 1'b1;
                        ld_val  = first_setup;
                    end else begin                        // rest
                        phase_d = PH_IDLE;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Request capture and read sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_q    <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_valid_q <= 1'b0;
            err_q      <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (accept) begin
                op_wr_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rd_valid_q <= leave_strobe && !op_wr_q;
            err_q      <= leave_strobe && expire;
            if (leave_strobe && !op_wr_q) begin
                rd_data_q <= mem_din & lane_mask;
            end
        end
    end

    // Output decode
    always_comb begin
        logic in_access;
        logic in_strobe;
        in_access   = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
        in_strobe   = (phase_q == PH_STROBE);
        req_ready   = (phase_q == PH_IDLE) || ((phase_q == PH_TURN) && at_last);
        mem_cs_n    = cfg_act.sel_strobe ? !in_strobe : !in_access;
        mem_oe_n    = !(in_strobe && !op_wr_q);
        mem_we_n    = !(in_strobe && op_wr_q);
        mem_addr    = in_access ? addr_q : '0;
        mem_dout_en = in_access && op_wr_q;
        mem_dout    = (in_access && op_wr_q) ? (wdata_q & lane_mask) : '0;
        rd_valid    = rd_valid_q;
        rd_data     = rd_data_q;
        err_timeout = err_q;
    end

endmodule

// File: rtl/amt_ctrl_chk.sv
module amt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rd_valid,
    input logic err_timeout,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dout_en,
    input logic sel_mode
);

    // R4
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R3
    strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R3
    select_only_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mode && !mem_cs_n) |-> (!mem_oe_n || !mem_we_n));

    // R2
    ready_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en));

    // R9
    rd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    // R7
    timeout_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> ($past(!mem_oe_n || !mem_we_n) && mem_oe_n && mem_we_n));

    // R8
    write_drives_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dout_en);

endmodule

bind amt_ctrl amt_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .err_timeout(err_timeout),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dout_en(mem_dout_en),
    .sel_mode   (cfg_act.sel_strobe)
);

// File: tb/sim_amt_ctrl.sv
`timescale 1ns/1ps
module sim_amt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [30:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        err_timeout;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [15:0] mem_addr, mem_dout, mem_din;
    logic        mem_wait = 1'b0;
    logic [7:0]  din_cnt = '0;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    // measurements of the last access
    int tot, acc, cs_cnt, stb, wrong, bad_addr, den, bad_dout, got_rd, rd_pos, err_cnt;
    logic [15:0] rd_val;
    bit cur_wide;

    always #2.5 clk = ~clk;

    amt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_timeout(err_timeout), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
        .mem_wait(mem_wait)
    );

    // memory model: data changes every strobe cycle (cycle k of a strobe shows k-1)
    always @(posedge clk) din_cnt <= mem_oe_n ? 8'd0 : din_cnt + 8'd1;
    assign mem_din = {mem_addr[7:0] ^ 8'h5A, din_cnt};

    function automatic logic [30:0] mk(bit sel, bit ext, bit wide, int ta,
                                        int rs, int rst, int rh, int ws, int wst, int wh);
        return (31'(sel) << 30) | (31'(ext) << 29) | (31'(wide) << 28) | (31'(ta) << 26) |
               (31'(rs) << 22) | (31'(rst) << 16) | (31'(rh) << 13) |
               (31'(ws) << 9) | (31'(wst) << 3) | 31'(wh);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [30:0] v);
        cfg_wdata = v;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge of the ready cycle ending the access
    task automatic access(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                          input int rel_at, input bit mid, input logic [30:0] mid_val);
        logic [15:0] exp_dout;
        exp_dout = cur_wide ? wd : (wd & 16'h00FF);
        req_write = wr; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        tot = 0; acc = 0; cs_cnt = 0; stb = 0; wrong = 0; bad_addr = 0;
        den = 0; bad_dout = 0; got_rd = 0; rd_pos = 0; err_cnt = 0; rd_val = '0;
        forever begin
            tot++;
            if (cfg_we) cfg_we = 1'b0;
            if (mid && tot == 1) begin cfg_wdata = mid_val; cfg_we = 1'b1; end
            if (mem_addr != 16'h0) begin acc++; if (mem_addr != addr) bad_addr++; end
            if (!mem_cs_n) cs_cnt++;
            if (wr ? !mem_oe_n : !mem_we_n) wrong++;
            if (!mem_oe_n || !mem_we_n) begin
                stb++;
                if (rel_at > 0 && stb == rel_at) mem_wait = 1'b0;
            end
            if (mem_dout_en) begin den++; if (mem_dout != exp_dout) bad_dout++; end
            if (rd_valid) begin got_rd++; rd_val = rd_data; rd_pos = tot; end
            if (err_timeout) err_cnt++;
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    // Compare the last access against values computed from the requirements
    task automatic verify(input bit wr, input int s, input int h, input int ta, input bit sel,
                          input logic [15:0] addr, input int exp_stb, input int exp_err);
        int exp_acc;
        logic [15:0] exp_rd;
        exp_acc = s + 1 + exp_stb + h + 1;
        exp_rd  = {addr[7:0] ^ 8'h5A, 8'(exp_stb - 1)};
        if (!cur_wide) exp_rd = exp_rd & 16'h00FF;
        chk(acc == exp_acc, "R1 access cycles", acc, exp_acc);
        chk(stb == exp_stb, "R1/R5/R6 strobe cycles", stb, exp_stb);
        chk(tot - acc == ta + 1, "R2 turnaround cycles", tot - acc, ta + 1);
        chk(cs_cnt == (sel ? exp_stb : exp_acc), "R3 chip-select cycles", cs_cnt,
            sel ? exp_stb : exp_acc);
        chk(wrong == 0, "R4 wrong strobe cycles", wrong, 0);
        chk(bad_addr == 0, "R8 address mismatches", bad_addr, 0);
        chk(den == (wr ? exp_acc : 0), "R8 drive-enable cycles", den, wr ? exp_acc : 0);
        chk(bad_dout == 0, "R8/R10 write data mismatches", bad_dout, 0);
        chk(err_cnt == exp_err, "R7 timeout pulses", err_cnt, exp_err);
        if (wr) begin
            chk(got_rd == 0, "R9 rd_valid on write", got_rd, 0);
        end else begin
            chk(got_rd == 1, "R9 rd_valid pulses", got_rd, 1);
            chk(rd_pos == s + exp_stb + 2, "R9 rd_valid cycle", rd_pos, s + exp_stb + 2);
            chk(rd_val == exp_rd, "R9/R10 read data", rd_val, exp_rd);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int idx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R12 strobes high", 0, 1);
        chk(!mem_dout_en && !rd_valid && !err_timeout, "R12 pulses low", 1, 0);
        chk(req_ready, "R12 ready high", req_ready, 1);

        // R1..R4, R8..R10 sweep: read fields (s,st,h), write fields mirrored
        idx = 0;
        for (int sel = 0; sel < 2; sel++) begin
            for (int ta = 0; ta < 3; ta += 2) begin
                for (int s = 0; s < 3; s++) begin
                    for (int st = 0; st < 3; st++) begin
                        for (int h = 0; h < 3; h++) begin
                            for (int wr = 0; wr < 2; wr++) begin
                                logic [15:0] a;
                                idx++;
                                cur_wide = idx[0];
                                a = 16'h0100 + 16'(idx);
                                set_cfg(mk(sel[0], 1'b0, cur_wide, ta, s, st, h, 2 - s, 2 - st, 2 - h));
                                access(wr[0], a, 16'hC3A0 ^ 16'(idx * 37), 0, 1'b0, '0);
                                if (wr == 1)
                                    verify(1'b1, 2 - s, 2 - h, ta, sel[0], a, 3 - st, 0);
                                else
                                    verify(1'b0, s, h, ta, sel[0], a, st + 1, 0);
                            end
                        end
                    end
                end
            end
        end

        // R1/R2 example widths: write 0/6/1, read 2/7/0, turnaround 2, back to back
        cur_wide = 1'b0;
        set_cfg(mk(1'b0, 1'b0, 1'b0, 2, 2, 7, 0, 0, 6, 1));
        access(1'b1, 16'h0A11, 16'h1234, 0, 1'b0, '0);
        verify(1'b1, 0, 1, 2, 1'b0, 16'h0A11, 7, 0);
        access(1'b0, 16'h0A22, 16'h0, 0, 1'b0, '0);
        verify(1'b0, 2, 0, 2, 1'b0, 16'h0A22, 8, 0);

        // R5 wait pin ignored when disabled
        cur_wide = 1'b1;
        set_cfg(mk(1'b0, 1'b0, 1'b1, 1, 1, 2, 1, 1, 2, 1));
        mem_wait = 1'b1;
        access(1'b0, 16'h0B01, 16'h0, 0, 1'b0, '0);
        verify(1'b0, 1, 1, 1, 1'b0, 16'h0B01, 3, 0);
        access(1'b1, 16'h0B02, 16'hBEEF, 0, 1'b0, '0);
        verify(1'b1, 1, 1, 1, 1'b0, 16'h0B02, 3, 0);
        mem_wait = 1'b0;

        // R6 wait stretches strobe; released late, released early
        set_cfg(mk(1'b0, 1'b1, 1'b1, 0, 1, 1, 0, 0, 1, 1));
        for (int rel = 1; rel < 8; rel += 3) begin
            mem_wait = 1'b1;
            access(1'b0, 16'h0C00 + 16'(rel), 16'h0, rel, 1'b0, '0);
            verify(1'b0, 1, 0, 0, 1'b0, 16'h0C00 + 16'(rel), (rel > 2) ? rel : 2, 0);
            mem_wait = 1'b1;
            access(1'b1, 16'h0D00 + 16'(rel), 16'h5AA5, rel, 1'b0, '0);
            verify(1'b1, 0, 1, 0, 1'b0, 16'h0D00 + 16'(rel), (rel > 2) ? rel : 2, 0);
        end
        mem_wait = 1'b0;

        // R7 timeout: strobe field 0, wait held, 0 + 256 strobe cycles
        set_cfg(mk(1'b1, 1'b1, 1'b1, 0, 0, 0, 0, 0, 0, 0));
        mem_wait = 1'b1;
        access(1'b0, 16'h0E01, 16'h0, 0, 1'b0, '0);
        verify(1'b0, 0, 0, 0, 1'b1, 16'h0E01, 256, 1);
        mem_wait = 1'b1;
        access(1'b1, 16'h0E02, 16'h7788, 0, 1'b0, '0);
        verify(1'b1, 0, 0, 0, 1'b1, 16'h0E02, 256, 1);
        mem_wait = 1'b0;

        // R11 config written mid-access applies only to the next access
        cur_wide = 1'b1;
        set_cfg(mk(1'b0, 1'b0, 1'b1, 1, 1, 1, 1, 1, 1, 1));
        access(1'b0, 16'h0F01, 16'h0, 0, 1'b1, mk(1'b1, 1'b0, 1'b0, 0, 0, 3, 0, 0, 3, 0));
        verify(1'b0, 1, 1, 1, 1'b0, 16'h0F01, 2, 0);
        cur_wide = 1'b0;
        access(1'b0, 16'h0F02, 16'h0, 0, 1'b0, '0);
        verify(1'b0, 0, 0, 0, 1'b1, 16'h0F02, 4, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule